// File: doc/BRIEF.md
# Serial Bus Command Sequencer

This block sits between a host and a byte-oriented serial bus engine. The host presents a command word. Its fields are start, address phase, stop, read-not-write, a 7-bit device address and a byte length. The sequencer first checks the command, then rejects it or accepts it. When it accepts a command it loads two residual down-counters with the length. The front-end counter tracks bytes that the engine moves on the wire. The back-end counter tracks bytes that the host moves through its data port. The two counters run independently of each other.

An accepted command walks through an address step and then a data step. The address step runs only when start is requested. In the data step the block raises requests toward the engine until both counters reach zero. It then raises command-complete and, when the command asked for one, a stop. Errors are sticky, and a single clear-errors strobe removes them. The three error classes are invalid command, NACK from the device, and a host access with no bytes left. A mode write picks which of several buses the engine drives.

Top module: `bus_cmd_seq`

## Requirements
- R1: After reset, cmd_comp is 1, all three error flags are 0, both counters are 0, bus_busy is 0, port_busy is all zeros and eng_port is 0.
- R2: A command with start=0, address phase=0, stop=0 and length 0 sets err_invalid. cmd_comp and both counters stay unchanged.
- R3: A command presented while cmd_comp is 0 sets err_invalid and leaves both counters unchanged.
- R4: An accepted command loads front_cnt and back_cnt with its length one cycle later and clears cmd_comp. With start=1 it raises eng_start_req, with eng_dev and eng_rnw taken from the command. A host access in the same cycle as an accepted command is not counted.
- R5: While eng_start_req is high, eng_addr_done with eng_addr_nack=1 sets err_nack, sets cmd_comp, clears bus_busy and pulses eng_stop for one cycle. With eng_addr_nack=0 it sets bus_busy and enters the data step.
- R6: In the data step, eng_data_req is high exactly when front_cnt is nonzero. Each eng_byte_done while eng_data_req is high lowers front_cnt by 1. An eng_byte_done while eng_data_req is low is ignored.
- R7: Each host_xfer lowers back_cnt by 1. A host_xfer when back_cnt is 0 sets err_backend and leaves back_cnt at 0. Both counters may decrement in the same cycle.
- R8: During a write (rnw=0), an eng_byte_done together with eng_byte_nack sets err_nack and ends the command. cmd_comp is set, bus_busy is cleared, eng_stop pulses and front_cnt keeps its value. During a read, eng_byte_nack is ignored and the byte counts normally.
- R9: In the data step, once both counters are 0, cmd_comp is set on the next edge. If the command had stop=1, eng_stop pulses for one cycle and bus_busy clears. If it had stop=0, bus_busy stays 1.
- R10: A mode write with a port number at or above NPORTS (5 by default, port field 3 bits wide) is ignored and eng_port keeps its value.
- R11: A mode write while bus_busy is 1 sets err_invalid and leaves eng_port unchanged.
- R12: clear_err zeroes all three error flags, both counters and bus_busy. It takes priority over every other event in the same cycle.
- R13: port_busy has bit eng_port set when bus_busy is 1, and is zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command word present this cycle |
| cmd_start | input | 1 | Command requests a start condition |
| cmd_addr_ph | input | 1 | Command includes an address phase |
| cmd_stop | input | 1 | Command ends with a stop |
| cmd_rnw | input | 1 | 1 = read, 0 = write |
| cmd_dev | input | 7 | Device address |
| cmd_len | input | LEN_W | Byte length |
| mode_wr | input | 1 | Mode write strobe |
| mode_port | input | PW | Requested bus port |
| clear_err | input | 1 | Clear errors and counters |
| host_xfer | input | 1 | Host moved one byte |
| eng_addr_done | input | 1 | Engine finished address step |
| eng_addr_nack | input | 1 | Address not acknowledged |
| eng_byte_done | input | 1 | Engine moved one byte |
| eng_byte_nack | input | 1 | Data byte not acknowledged |
| eng_start_req | output | 1 | Request start/address step |
| eng_addr_phase | output | 1 | Address phase flag of current command |
| eng_data_req | output | 1 | Request a data byte |
| eng_stop | output | 1 | One-cycle stop request |
| eng_dev | output | 7 | Device address to engine |
| eng_rnw | output | 1 | Direction to engine |
| eng_port | output | PW | Selected bus port |
| front_cnt | output | LEN_W | Bus-side residual count |
| back_cnt | output | LEN_W | Host-side residual count |
| cmd_comp | output | 1 | Command complete |
| bus_busy | output | 1 | Bus held by this block |
| port_busy | output | NPORTS | Per-port busy view |
| err_invalid | output | 1 | Invalid command error |
| err_nack | output | 1 | NACK error |
| err_backend | output | 1 | Back-end access error |

## Verification
An engine byte completion and a host byte access can land in the same cycle. The front-end and back-end counters must then both fall by one, with neither update lost. The random phase drives eng_byte_done and host_xfer independently at about one half each. Many cycles therefore carry both strobes at once, and a bench model updates its two counts separately and compares them every cycle. The same phase also places write-data NACKs next to host accesses. In that case termination must freeze front_cnt while back_cnt still counts.

// File: rtl/bus_cmd_seq.sv
module bus_cmd_seq #(
  parameter int NPORTS = 5,
  parameter int LEN_W  = 8,
  localparam int PW    = $clog2(NPORTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_start,
  input  logic              cmd_addr_ph,
  input  logic              cmd_stop,
  input  logic              cmd_rnw,
  input  logic [6:0]        cmd_dev,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic              mode_wr,
  input  logic [PW-1:0]     mode_port,
  input  logic              clear_err,
  input  logic              host_xfer,
  input  logic              eng_addr_done,
  input  logic              eng_addr_nack,
  input  logic              eng_byte_done,
  input  logic              eng_byte_nack,
  output logic              eng_start_req,
  output logic              eng_addr_phase,
  output logic              eng_data_req,
  output logic              eng_stop,
  output logic [6:0]        eng_dev,
  output logic              eng_rnw,
  output logic [PW-1:0]     eng_port,
  output logic [LEN_W-1:0]  front_cnt,
  output logic [LEN_W-1:0]  back_cnt,
  output logic              cmd_comp,
  output logic              bus_busy,
  output logic [NPORTS-1:0] port_busy,
  output logic              err_invalid,
  output logic              err_nack,
  output logic              err_backend
);

  localparam logic [PW-1:0] NP = PW'(NPORTS);

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA} st_t;
  st_t st;
  logic stop_q;

  wire empty_cmd = !cmd_start && !cmd_addr_ph && !cmd_stop && (cmd_len == '0);
  wire accept    = cmd_valid && !empty_cmd && cmd_comp;
  wire reject    = cmd_valid && (empty_cmd || !cmd_comp);
  wire port_ok   = mode_wr && (mode_port < NP);
  wire byte_ok   = eng_data_req && eng_byte_done;
  wire wr_nack   = byte_ok && !eng_rnw && eng_byte_nack;
  wire finish    = (st == S_DATA) && (front_cnt == '0) && (back_cnt == '0);

  assign eng_start_req = (st == S_ADDR);
  assign eng_data_req  = (st == S_DATA) && (front_cnt != '0);
  assign port_busy     = bus_busy ? (NPORTS'(1) << eng_port) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      stop_q <= 1'b0;
      eng_addr_phase <= 1'b0;
      eng_dev <= '0;
      eng_rnw <= 1'b0;
      eng_port <= '0;
      eng_stop <= 1'b0;
      front_cnt <= '0;
      back_cnt <= '0;
      cmd_comp <= 1'b1;
      bus_busy <= 1'b0;
      err_invalid <= 1'b0;
      err_nack <= 1'b0;
      err_backend <= 1'b0;
    end else begin
      eng_stop <= 1'b0;
      if (port_ok && !bus_busy) eng_port <= mode_port;
      if (reject || (port_ok && bus_busy)) err_invalid <= 1'b1;

      if (accept) begin
        eng_dev <= cmd_dev;
        eng_rnw <= cmd_rnw;
        stop_q <= cmd_stop;
        eng_addr_phase <= cmd_addr_ph;
        cmd_comp <= 1'b0;
        st <= cmd_start ? S_ADDR : S_DATA;
      end

      case (st)
        S_ADDR: if (eng_addr_done) begin
          if (eng_addr_nack) begin
            err_nack <= 1'b1;
            st <= S_IDLE;
            cmd_comp <= 1'b1;
            eng_stop <= 1'b1;
            bus_busy <= 1'b0;
          end else begin
            bus_busy <= 1'b1;
            st <= S_DATA;
          end
        end
        S_DATA: if (wr_nack) begin
          err_nack <= 1'b1;
          st <= S_IDLE;
          cmd_comp <= 1'b1;
          eng_stop <= 1'b1;
          bus_busy <= 1'b0;
        end else if (finish) begin
          st <= S_IDLE;
          cmd_comp <= 1'b1;
          if (stop_q) begin
            eng_stop <= 1'b1;
            bus_busy <= 1'b0;
          end
        end
        default: ;
      endcase

      if (accept) front_cnt <= cmd_len;
      else if (byte_ok && !wr_nack) front_cnt <= front_cnt - 1'b1;

      if (accept) back_cnt <= cmd_len;
      else if (host_xfer) begin
        if (back_cnt == '0) err_backend <= 1'b1;
        else back_cnt <= back_cnt - 1'b1;
      end

      if (clear_err) begin
        err_invalid <= 1'b0;
        err_nack <= 1'b0;
        err_backend <= 1'b0;
        front_cnt <= '0;
        back_cnt <= '0;
        bus_busy <= 1'b0;
      end
    end
  end

  a_r3_reject_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_comp && !clear_err) |=> err_invalid);

  a_r4_load_len: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_comp && cmd_len != '0 && !clear_err) |=>
      (front_cnt == $past(cmd_len) && back_cnt == $past(cmd_len) && !cmd_comp));

  a_r7_backend_err: assert property (@(posedge clk) disable iff (!rst_n)
    (host_xfer && back_cnt == '0 && !cmd_valid && !clear_err) |=> (err_backend && back_cnt == '0));

  a_r9_stop_done: assert property (@(posedge clk) disable iff (!rst_n)
    eng_stop |-> (cmd_comp && !bus_busy));

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_comp |-> (!eng_start_req && !eng_data_req));

  a_r13_port_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(port_busy) && (bus_busy == (port_busy != '0)));

endmodule

// File: tb/bus_cmd_seq_tb.sv
module bus_cmd_seq_tb;
  localparam int NPORTS = 5;
  localparam int LEN_W = 8;
  localparam int PW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 0, cmd_start = 0, cmd_addr_ph = 0, cmd_stop = 0, cmd_rnw = 0;
  logic [6:0] cmd_dev = '0;
  logic [LEN_W-1:0] cmd_len = '0;
  logic mode_wr = 0;
  logic [PW-1:0] mode_port = '0;
  logic clear_err = 0, host_xfer = 0;
  logic eng_addr_done = 0, eng_addr_nack = 0, eng_byte_done = 0, eng_byte_nack = 0;
  logic eng_start_req, eng_addr_phase, eng_data_req, eng_stop, eng_rnw;
  logic [6:0] eng_dev;
  logic [PW-1:0] eng_port;
  logic [LEN_W-1:0] front_cnt, back_cnt;
  logic cmd_comp, bus_busy, err_invalid, err_nack, err_backend;
  logic [NPORTS-1:0] port_busy;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  bus_cmd_seq #(.NPORTS(NPORTS), .LEN_W(LEN_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_start(cmd_start),
    .cmd_addr_ph(cmd_addr_ph), .cmd_stop(cmd_stop), .cmd_rnw(cmd_rnw),
    .cmd_dev(cmd_dev), .cmd_len(cmd_len), .mode_wr(mode_wr), .mode_port(mode_port),
    .clear_err(clear_err), .host_xfer(host_xfer), .eng_addr_done(eng_addr_done),
    .eng_addr_nack(eng_addr_nack), .eng_byte_done(eng_byte_done),
    .eng_byte_nack(eng_byte_nack), .eng_start_req(eng_start_req),
    .eng_addr_phase(eng_addr_phase), .eng_data_req(eng_data_req),
    .eng_stop(eng_stop), .eng_dev(eng_dev), .eng_rnw(eng_rnw), .eng_port(eng_port),
    .front_cnt(front_cnt), .back_cnt(back_cnt), .cmd_comp(cmd_comp),
    .bus_busy(bus_busy), .port_busy(port_busy), .err_invalid(err_invalid),
    .err_nack(err_nack), .err_backend(err_backend));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 0; mode_wr = 0; clear_err = 0; host_xfer = 0;
    eng_addr_done = 0; eng_addr_nack = 0; eng_byte_done = 0; eng_byte_nack = 0;
  endtask

  task automatic send_cmd(bit st, bit ap, bit sp, bit rnw, logic [6:0] dev, logic [LEN_W-1:0] len);
    cmd_valid = 1; cmd_start = st; cmd_addr_ph = ap; cmd_stop = sp;
    cmd_rnw = rnw; cmd_dev = dev; cmd_len = len;
  endtask

  function automatic int exp_pbusy(bit busy, int port);
    return busy ? (1 << port) : 0;
  endfunction

  task automatic clr();
    clear_err = 1; tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int mf, mb, len, cyc;
    bit rnw, sp, mbusy, done, bd, bn, hx;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    chk("R1 cmd_comp", cmd_comp, 1);
    chk("R1 errors", {err_invalid, err_nack, err_backend}, 0);
    chk("R1 counters", front_cnt + back_cnt, 0);
    chk("R1 busy", bus_busy, 0);
    chk("R1 port_busy", port_busy, 0);
    chk("R1 port", eng_port, 0);

    send_cmd(0, 0, 0, 0, 7'h11, 0); tick();
    chk("R2 err_invalid", err_invalid, 1);
    chk("R2 cmd_comp kept", cmd_comp, 1);
    chk("R2 front kept", front_cnt, 0);
    clr();
    chk("R12 invalid cleared", err_invalid, 0);

    mode_wr = 1; mode_port = 7; tick();
    chk("R10 bad port ignored", eng_port, 0);
    mode_wr = 1; mode_port = 5; tick();
    chk("R10 port at limit ignored", eng_port, 0);
    mode_wr = 1; mode_port = 2; tick();
    chk("R10 good port", eng_port, 2);
    chk("R10 no error", err_invalid, 0);

    send_cmd(1, 1, 0, 0, 7'h55, 3); host_xfer = 1; tick();
    chk("R4 front load", front_cnt, 3);
    chk("R4 back load (host ignored)", back_cnt, 3);
    chk("R4 cmd_comp low", cmd_comp, 0);
    chk("R4 start req", eng_start_req, 1);
    chk("R4 dev", eng_dev, 'h55);
    chk("R4 rnw", eng_rnw, 0);

    eng_addr_done = 1; tick();
    chk("R5 busy after ack", bus_busy, 1);
    chk("R6 data req", eng_data_req, 1);
    chk("R13 port_busy", port_busy, exp_pbusy(1, 2));

    eng_byte_done = 1; tick();
    chk("R6 front dec", front_cnt, 2);
    host_xfer = 1; tick();
    chk("R7 back dec", back_cnt, 2);
    eng_byte_done = 1; host_xfer = 1; tick();
    chk("R7 both dec front", front_cnt, 1);
    chk("R7 both dec back", back_cnt, 1);
    eng_byte_done = 1; tick();
    chk("R6 front zero", front_cnt, 0);
    chk("R6 data req low", eng_data_req, 0);
    eng_byte_done = 1; tick();
    chk("R6 extra byte ignored", front_cnt, 0);
    host_xfer = 1; tick();
    chk("R9 not yet complete", cmd_comp, 0);
    tick();
    chk("R9 complete", cmd_comp, 1);
    chk("R9 no stop keeps busy", bus_busy, 1);
    chk("R9 no stop pulse", eng_stop, 0);

    mode_wr = 1; mode_port = 1; tick();
    chk("R11 err_invalid", err_invalid, 1);
    chk("R11 port kept", eng_port, 2);
    clr();
    chk("R12 busy cleared", bus_busy, 0);
    chk("R13 port_busy idle", port_busy, 0);

    send_cmd(1, 1, 1, 1, 7'h2a, 2); tick();
    send_cmd(1, 1, 1, 0, 7'h01, 9); tick();
    chk("R3 err_invalid", err_invalid, 1);
    chk("R3 front kept", front_cnt, 2);
    chk("R3 dev kept", eng_dev, 'h2a);
    eng_addr_done = 1; tick();
    eng_byte_done = 1; eng_byte_nack = 1; tick();
    chk("R8 read nack ignored", front_cnt, 1);
    chk("R8 read nack no err", err_nack, 0);
    eng_byte_done = 1; host_xfer = 1; tick();
    host_xfer = 1; tick();
    tick();
    chk("R9 complete with stop", cmd_comp, 1);
    chk("R9 stop pulse", eng_stop, 1);
    chk("R9 busy cleared", bus_busy, 0);
    tick();
    chk("R9 stop one cycle", eng_stop, 0);
    clr();

    host_xfer = 1; tick();
    chk("R7 backend err", err_backend, 1);
    chk("R7 back stays zero", back_cnt, 0);
    clr();

    send_cmd(1, 1, 1, 0, 7'h33, 2); tick();
    eng_addr_done = 1; eng_addr_nack = 1; tick();
    chk("R5 addr nack err", err_nack, 1);
    chk("R5 addr nack comp", cmd_comp, 1);
    chk("R5 addr nack stop", eng_stop, 1);
    chk("R5 addr nack busy", bus_busy, 0);
    clr();

    send_cmd(1, 1, 0, 0, 7'h34, 2); tick();
    eng_addr_done = 1; tick();
    eng_byte_done = 1; eng_byte_nack = 1; tick();
    chk("R8 write nack err", err_nack, 1);
    chk("R8 write nack comp", cmd_comp, 1);
    chk("R8 write nack stop", eng_stop, 1);
    chk("R8 front frozen", front_cnt, 2);
    host_xfer = 1; tick();
    clr();
    chk("R12 all errors clear", {err_invalid, err_nack, err_backend}, 0);
    chk("R12 counters zero", front_cnt + back_cnt, 0);

    for (int t = 0; t < 60; t++) begin
      len = 1 + ($urandom % 8);
      rnw = $urandom % 2;
      sp = $urandom % 2;
      send_cmd(1, 1, sp, rnw, 7'($urandom), LEN_W'(len)); tick();
      chk("R4 random load", front_cnt, len);
      eng_addr_done = 1; eng_addr_nack = ($urandom % 5 == 0);
      if (eng_addr_nack) begin
        tick();
        chk("R5 random addr nack", {err_nack, cmd_comp, bus_busy}, 3'b110);
        clr();
        continue;
      end
      tick();
      chk("R5 random busy", bus_busy, 1);
      mf = len; mb = len; mbusy = 1; done = 0; cyc = 0;
      while (!done && cyc < 100) begin
        cyc++;
        bd = $urandom % 2;
        bn = !rnw && ($urandom % 10 == 0);
        hx = (mb != 0) && ($urandom % 2);
        eng_byte_done = bd; eng_byte_nack = bn; host_xfer = hx;
        if (bd && mf != 0 && !rnw && bn) begin
          done = 1; mbusy = 0;
        end else if (mf == 0 && mb == 0) begin
          done = 1; if (sp) mbusy = 0;
        end else if (bd && mf != 0) mf--;
        if (hx) mb--;
        tick();
        chk("R7 random front", front_cnt, mf);
        chk("R7 random back", back_cnt, mb);
        chk("R9 random comp", cmd_comp, done);
        chk("R13 random busy", port_busy, exp_pbusy(mbusy, 2));
      end
      if (err_nack || !sp) clr();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule